// File: doc/BRIEF.md
# Per-Core Store Buffer with Forwarding and Fence Drain

This block sits between a core's execution pipeline and its L1 data cache. The pipeline hands it stores in program order. Each store waits in a small queue until the coherence side confirms that this core owns the line, and it then commits to the cache. Stores leave the queue oldest first, and only the oldest one may have an ownership request in flight.

Loads from the same core look up the queue in the same cycle. Each byte a load asks for comes from the youngest buffered store to that word that enables the byte. A buffered store can therefore be seen locally before any other agent can see it. A load with no match is not held back by older buffered stores.

A fence, or the start of a locked read-modify-write, is presented as a level request. While that request is high and the queue still holds entries, no younger load or store is accepted. The drained flag tells the pipeline when the request is satisfied.

Top module: `sb_store_buffer`

## Requirements
- R1: After reset the queue is empty: `drained`=1, `st_ready`=1, `ld_ready`=1, `own_req`=0, `cm_valid`=0 and `ld_hit`=0.
- R2: A store is accepted on a cycle with `st_valid`=1 and `st_ready`=1. Stores reach the commit port (`cm_addr`, `cm_data`, `cm_be`) in exactly the order they were accepted, and a store accepted in the same cycle as a commit is kept.
- R3: `own_req` is high exactly when the queue is non-empty and no commit is pending. `own_addr` is the address of the oldest entry. Once raised, `own_req` stays high until `own_ack` is seen.
- R4: A cycle with `own_req`=1 and `own_ack`=1 is followed by exactly one cycle with `cm_valid`=1, which carries the oldest entry. That entry leaves the queue at the end of that cycle.
- R5: `own_ack` while `own_req`=0 is ignored: it produces no `cm_valid` in the next cycle.
- R6: The bit `ld_fwd_be[b]` is 1 when some buffered entry has the word address `ld_addr` and byte enable b set. Byte b of `ld_data` (bits 8b+7..8b) comes from the youngest such entry. Bytes that are not forwarded read 0. `ld_hit` is the OR of `ld_fwd_be`. The outputs are valid only when `ld_valid`=1 and `ld_ready`=1, and are 0 otherwise.
- R7: With no fence pending, a load whose address matches no entry has `ld_ready`=1 and `ld_hit`=0 even while older stores are buffered.
- R8: With 8 entries buffered, `st_ready`=0 and a presented store is not taken.
- R9: While `fence_req`=1 and the queue is non-empty, `st_ready`=0, `ld_ready`=0 and `ld_hit`=0. Commits continue during this time.
- R10: `drained` is 1 exactly when the queue holds no entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store presented by the pipeline |
| st_addr | input | AW (32) | Store word address |
| st_data | input | DW (32) | Store data |
| st_be | input | DW/8 (4) | Store byte enables |
| st_ready | output | 1 | Store can be accepted this cycle |
| ld_valid | input | 1 | Load lookup presented |
| ld_addr | input | AW (32) | Load word address |
| ld_ready | output | 1 | Load may proceed (not blocked by a fence) |
| ld_hit | output | 1 | At least one byte forwarded |
| ld_fwd_be | output | DW/8 (4) | Bytes supplied by the buffer |
| ld_data | output | DW (32) | Forwarded data, 0 in bytes that are not forwarded |
| fence_req | input | 1 | Fence or locked-operation start, held until drained |
| drained | output | 1 | Queue is empty |
| own_req | output | 1 | Ownership request for the oldest entry's line |
| own_addr | output | AW (32) | Address of the oldest entry |
| own_ack | input | 1 | Ownership granted |
| cm_valid | output | 1 | Commit write to the cache this cycle |
| cm_addr | output | AW (32) | Commit address |
| cm_data | output | DW (32) | Commit data |
| cm_be | output | DW/8 (4) | Commit byte enables |

## Verification
The bench aims several stores with different byte enables at the same word. Each byte of a load must then come from the youngest writer of that byte. A design that forwarded whole words, or scanned from the oldest end, would return stale bytes. The bench fills the queue to eight while ownership is withheld and pushes a ninth store: a design with a wrong full test would overwrite the oldest entry or lose the store. Fences are raised while entries are pending and acknowledges are given while the queue is idle. A design that leaks a load past a fence, or commits on a stray acknowledge, shows up as a wrong `ld_ready` or a spurious `cm_valid`. A long mixed random run also pushes stores on the same cycle as commits, which catches count updates that drop one of the two.

// File: rtl/sb_pkg.sv
// Shared types for the store buffer.
package sb_pkg;
    // Commit sequencer: wait for ownership of the head, then write it.
    typedef enum logic {
        CM_OWN   = 1'b0,
        CM_WRITE = 1'b1
    } cm_state_e;
endpackage

// File: rtl/sb_fifo.sv
// sb_fifo: the ordered entry storage of the store buffer.
// Entries are written at the tail and removed at the head. Every entry
// is also presented in age order (index 0 = oldest) for lookups.
// Assumes DEPTH is a power of two, so pointers wrap on their own.
module sb_fifo #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int NB   = DW / 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic [NB-1:0] push_be,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic          age_valid [DEPTH],
    output logic [AW-1:0] age_addr  [DEPTH],
    output logic [DW-1:0] age_data  [DEPTH],
    output logic [NB-1:0] age_be    [DEPTH]
);
    logic [AW-1:0] mem_addr [DEPTH];
    logic [DW-1:0] mem_data [DEPTH];
    logic [NB-1:0] mem_be   [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    // Write the incoming store into the tail slot.
    always_ff @(posedge clk) begin
        if (push) begin
            mem_addr[wr_ptr] <= push_addr;
            mem_data[wr_ptr] <= push_data;
            mem_be[wr_ptr]   <= push_be;
        end
    end

    // Advance the pointers and keep the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Present the slots in age order, oldest first.
    for (genvar k = 0; k < DEPTH; k++) begin : g_age
        logic [PW-1:0] slot;
        assign slot         = rd_ptr + PW'(k);
        assign age_valid[k] = (count > CW'(k));
        assign age_addr[k]  = mem_addr[slot];
        assign age_data[k]  = mem_data[slot];
        assign age_be[k]    = mem_be[slot];
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)));
    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(count));
endmodule

// File: rtl/sb_fwd.sv
// sb_fwd: byte-granular store-to-load forwarding.
// Scans the entries from oldest to youngest, so a younger writer of a
// byte overrides an older one. Purely combinational.
module sb_fwd #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int NB   = DW / 8
) (
    input  logic          age_valid [DEPTH],
    input  logic [AW-1:0] age_addr  [DEPTH],
    input  logic [DW-1:0] age_data  [DEPTH],
    input  logic [NB-1:0] age_be    [DEPTH],
    input  logic [AW-1:0] ld_addr,
    output logic [NB-1:0] hit_be,
    output logic [DW-1:0] hit_data
);
    // Merge the matching bytes, the youngest writer winning.
    always_comb begin
        hit_be   = '0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (age_valid[k] && (age_addr[k] == ld_addr)) begin
                for (int b = 0; b < NB; b++) begin
                    if (age_be[k][b]) begin
                        hit_be[b]          = 1'b1;
                        hit_data[8*b +: 8] = age_data[k][8*b +: 8];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sb_commit.sv
// sb_commit: ownership handshake and commit timing for the head entry.
// Only the head may have a request outstanding. A grant moves the
// sequencer to the write state, and the head is written and popped in
// the next cycle. Assumes head_valid stays high until that pop.
module sb_commit (
    input  logic clk,
    input  logic rst_n,
    input  logic head_valid,
    input  logic own_ack,
    output logic own_req,
    output logic cm_fire
);
    import sb_pkg::*;
    cm_state_e state;

    // Step from request to write on a grant, and back after one write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CM_OWN;
        end else begin
            case (state)
                CM_OWN:   if (head_valid && own_ack) state <= CM_WRITE;
                CM_WRITE: state <= CM_OWN;
                default:  state <= CM_OWN;
            endcase
        end
    end

    // Decode the handshake outputs from the state.
    always_comb begin
        own_req = (state == CM_OWN) && head_valid;
        cm_fire = (state == CM_WRITE);
    end

    // R4
    commit_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_fire |-> $past(own_req && own_ack));
    // R4
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_fire |=> !cm_fire);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_req && !own_ack) |=> own_req);
endmodule

// File: rtl/sb_store_buffer.sv
// sb_store_buffer: per-core store buffer placed in front of the L1 data cache.
// Stores enter in program order and commit oldest first, each one after
// its ownership grant. Loads forward from the buffer byte by byte. A
// fence or locked-operation request blocks younger accesses until the
// buffer is empty. Addresses are word addresses.
module sb_store_buffer #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int NB   = DW / 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [NB-1:0] st_be,
    output logic          st_ready,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_ready,
    output logic          ld_hit,
    output logic [NB-1:0] ld_fwd_be,
    output logic [DW-1:0] ld_data,
    input  logic          fence_req,
    output logic          drained,
    output logic          own_req,
    output logic [AW-1:0] own_addr,
    input  logic          own_ack,
    output logic          cm_valid,
    output logic [AW-1:0] cm_addr,
    output logic [DW-1:0] cm_data,
    output logic [NB-1:0] cm_be
);
    logic [CW-1:0] count;
    logic          age_valid [DEPTH];
    logic [AW-1:0] age_addr  [DEPTH];
    logic [DW-1:0] age_data  [DEPTH];
    logic [NB-1:0] age_be    [DEPTH];
    logic [NB-1:0] hit_be;
    logic [DW-1:0] hit_data;
    logic          push, fence_block, ld_go;

    sb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(st_addr), .push_data(st_data), .push_be(st_be),
        .pop(cm_valid), .count(count),
        .age_valid(age_valid), .age_addr(age_addr),
        .age_data(age_data), .age_be(age_be)
    );

    sb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
        .age_valid(age_valid), .age_addr(age_addr),
        .age_data(age_data), .age_be(age_be),
        .ld_addr(ld_addr), .hit_be(hit_be), .hit_data(hit_data)
    );

    sb_commit u_commit (
        .clk(clk), .rst_n(rst_n),
        .head_valid(age_valid[0]), .own_ack(own_ack),
        .own_req(own_req), .cm_fire(cm_valid)
    );

    // Acceptance and fence gating at the pipeline side.
    always_comb begin
        drained     = (count == '0);
        fence_block = fence_req && !drained;
        st_ready    = (count != CW'(DEPTH)) && !fence_block;
        ld_ready    = !fence_block;
        push        = st_valid && st_ready;
        ld_go       = ld_valid && ld_ready;
    end

    // Forwarding results, zero unless a load proceeds.
    always_comb begin
        ld_fwd_be = ld_go ? hit_be   : '0;
        ld_data   = ld_go ? hit_data : '0;
        ld_hit    = |ld_fwd_be;
    end

    // The head entry drives both the ownership and the commit ports.
    always_comb begin
        own_addr = age_addr[0];
        cm_addr  = age_addr[0];
        cm_data  = age_data[0];
        cm_be    = age_be[0];
    end

    // R9
    fence_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_req && !drained) |-> (!st_ready && !ld_ready && !ld_hit));
    // R2
    head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> ($stable(cm_addr) && $stable(cm_data) && $stable(cm_be)));
    // R10
    drained_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> !own_req && !cm_valid);
endmodule

// File: tb/sim_sb_store_buffer.sv
`timescale 1ns/1ps
module sim_sb_store_buffer;
    localparam int AW = 32, DW = 32, NB = 4, DEPTH = 8;

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [NB-1:0] be;
    } ent_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic st_valid = 1'b0, ld_valid = 1'b0, fence_req = 1'b0, own_ack = 1'b0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [NB-1:0] st_be = '0;
    logic st_ready, ld_ready, ld_hit, drained, own_req, cm_valid;
    logic [NB-1:0] ld_fwd_be, cm_be;
    logic [DW-1:0] ld_data, cm_data;
    logic [AW-1:0] own_addr, cm_addr;

    int vectors = 0, fails = 0;
    bit done = 0;
    ent_t q[$];
    bit acked = 0, ack_idle_prev = 0;

    sb_store_buffer u0 (.*);

    always #2.5 clk = ~clk;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, compare with the model, then advance the model.
    task automatic step(bit stv, logic [AW-1:0] sa, logic [DW-1:0] sd, logic [NB-1:0] sbe,
                        bit ldv, logic [AW-1:0] la, bit fen, bit ack);
        bit blk, e_st, e_ld, e_go, e_own;
        logic [NB-1:0] fbe;
        logic [DW-1:0] fd;
        @(negedge clk);
        st_valid = stv; st_addr = sa; st_data = sd; st_be = sbe;
        ld_valid = ldv; ld_addr = la; fence_req = fen; own_ack = ack;
        #1;
        blk  = fen && (q.size() != 0);
        e_st = (q.size() < DEPTH) && !blk;
        e_ld = !blk;
        e_go = ldv && e_ld;
        fbe = '0; fd = '0;
        foreach (q[i])
            if (q[i].a == la)
                for (int b = 0; b < NB; b++)
                    if (q[i].be[b]) begin fbe[b] = 1'b1; fd[8*b +: 8] = q[i].d[8*b +: 8]; end
        if (!e_go) begin fbe = '0; fd = '0; end
        e_own = (q.size() != 0) && !acked;
        chk(blk ? "R9" : (q.size() >= DEPTH ? "R8" : "R2"), "st_ready", 64'(st_ready), 64'(e_st));
        chk(blk ? "R9" : "R7", "ld_ready", 64'(ld_ready), 64'(e_ld));
        chk(!e_ld ? "R9" : ((fbe == '0 && q.size() != 0) ? "R7" : "R6"), "ld_hit", 64'(ld_hit), 64'(|fbe));
        chk("R6", "ld_fwd_be", 64'(ld_fwd_be), 64'(fbe));
        chk("R6", "ld_data", 64'(ld_data), 64'(fd));
        chk("R10", "drained", 64'(drained), 64'(q.size() == 0));
        chk("R3", "own_req", 64'(own_req), 64'(e_own));
        if (e_own) chk("R3", "own_addr", 64'(own_addr), 64'(q[0].a));
        chk(ack_idle_prev ? "R5" : "R4", "cm_valid", 64'(cm_valid), 64'(acked));
        if (acked) begin
            chk("R2", "cm_addr", 64'(cm_addr), 64'(q[0].a));
            chk("R2", "cm_data", 64'(cm_data), 64'(q[0].d));
            chk("R2", "cm_be", 64'(cm_be), 64'(q[0].be));
        end
        @(posedge clk);
        ack_idle_prev = ack && !e_own && !acked;
        if (acked) begin void'(q.pop_front()); acked = 0; end
        else if (e_own && ack) acked = 1;
        if (stv && e_st) q.push_back('{a: sa, d: sd, be: sbe});
    endtask

    initial begin
        // R1: outputs during and right after reset
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R1", "drained", 64'(drained), 64'd1);
        chk("R1", "st_ready", 64'(st_ready), 64'd1);
        chk("R1", "ld_ready", 64'(ld_ready), 64'd1);
        chk("R1", "own_req", 64'(own_req), 64'd0);
        chk("R1", "cm_valid", 64'(cm_valid), 64'd0);
        chk("R1", "ld_hit", 64'(ld_hit), 64'd0);
        rst_n = 1'b1;
        @(posedge clk);

        // R8: nine stores with ownership withheld, bytes overlapping on two words
        for (int i = 0; i < 9; i++)
            step(1, 32'h10 + 32'(i % 2), 32'hA0B0C0D0 + 32'(i * 32'h01010101),
                 4'(1 << (i % 4)) | 4'b0001, 0, '0, 0, 0);
        // R6: youngest writer per byte; R7: miss with stores buffered
        step(0, '0, '0, '0, 1, 32'h10, 0, 0);
        step(0, '0, '0, '0, 1, 32'h11, 0, 0);
        step(0, '0, '0, '0, 1, 32'h30, 0, 0);
        // R9: fence while draining, loads and stores held back
        for (int i = 0; i < 30; i++)
            step(1, 32'h40, 32'h12345678, 4'hF, 1, 32'h10, 1, 1);
        // R5: acknowledge while idle
        step(0, '0, '0, '0, 0, '0, 0, 1);
        step(0, '0, '0, '0, 0, '0, 0, 0);
        // R4/R2: push on the commit cycle
        step(1, 32'h20, 32'h11112222, 4'hF, 0, '0, 0, 1);
        step(1, 32'h20, 32'h33334444, 4'h3, 1, 32'h20, 0, 1);
        step(1, 32'h21, 32'h55556666, 4'hC, 1, 32'h20, 0, 0);

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            step(r < 55, 32'($urandom_range(0, 3)), $urandom, 4'($urandom_range(0, 15)),
                 $urandom_range(0, 1) == 1, 32'($urandom_range(0, 4)),
                 $urandom_range(0, 9) == 0, $urandom_range(0, 2) != 0);
        end
        // Drain and check idle
        for (int i = 0; i < 30; i++) step(0, '0, '0, '0, 0, '0, 1, 1);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule